// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache with LRU Replacement

This block is a read-only cache placed between a requester and a slower block-wide memory. The byte address is split into three parts. The low bits pick a byte inside a block. The middle bits pick one of the sets. The remaining upper bits form the tag. Each set holds two ways, and each way has a valid flag, a tag and one data block. A lookup compares the address tag against both ways of the chosen set at the same time. On a hit, the block returns the selected byte one cycle later and leaves the contents unchanged.

On a miss, the block raises a memory request carrying the block address and drops its ready output until the memory returns the whole block. It writes the block into an empty way of the set if one exists. Otherwise it overwrites the way that was used least recently. It answers the requester in the cycle after the block arrives. Each set keeps one recency bit that names the way to replace next. Every hit and every fill of a way points that bit at the other way.

Top module: `assoc2_cache`

## Requirements
- R1: The byte offset is req_addr[3:0], the set index is req_addr[5:4] and the tag is req_addr[15:6] (defaults: 16-byte blocks, four sets). Any byte of a resident block hits, and an address that differs only in its set bits is looked up in a different set.
- R2: After reset every way is invalid. req_ready is 1, resp_valid is 0 and mem_req is 0, and the first access to any address misses.
- R3: An accepted request whose tag matches a valid way of its set gives resp_valid=1 and resp_hit=1 in the next cycle. resp_data is byte req_addr[3:0] of that block, and no memory request is made.
- R4: An accepted request that misses raises mem_req in the next cycle with mem_baddr = req_addr >> 4. It holds req_ready at 0 until the cycle after mem_valid. It answers with resp_valid=1, resp_hit=0 and the addressed byte of the fetched block in the cycle after mem_valid.
- R5: A miss fills an invalid way of its set before any valid way is replaced, and way 0 when both ways are invalid.
- R6: When both ways of the set are valid, a miss replaces the least recently used way, and hits update recency. In one set, references to tags A,B,A,C,B,A,B give miss, miss, hit, miss, miss, miss, hit.
- R7: Fills and hits in one set change neither the contents nor the recency of any other set.
- R8: Two different tags held in the same set each return their own data, and no lookup ever matches both ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Requester presents a read address |
| req_addr | input | ADDR_W | Byte address to read |
| req_ready | output | 1 | High when a request can be accepted (low while a miss is being served) |
| resp_valid | output | 1 | One-cycle pulse carrying the answer |
| resp_hit | output | 1 | 1 when the answer came from the cache, 0 when it came from a fill |
| resp_data | output | BYTE_W | The requested byte |
| mem_req | output | 1 | Block fetch in progress |
| mem_baddr | output | ADDR_W-OFF_W | Block address to fetch |
| mem_valid | input | 1 | Memory delivers the block (one cycle) |
| mem_block | input | BYTE_W*2^OFF_W | Whole block, byte i in bits [8i+7:8i] |

## Verification
The two activities that meet in one cycle are the completion of a fill and a new request that is already waiting at the port. The bench issues a miss and then, while the fetch is pending, holds a request for another byte of the same block. It expects that request to stay stalled until the fill lands. The request must then be accepted in the very next cycle and answered as a hit with the byte the memory just delivered, with no second fetch. Recency handling is judged by the hit/miss pattern of a fixed reference string in one set while another set's lines stay resident.

// File: rtl/assoc2_cache.sv
module assoc2_cache #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 4,
  parameter int SET_W  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  input  logic [ADDR_W-1:0]                 req_addr,
  output logic                              req_ready,
  output logic                              resp_valid,
  output logic                              resp_hit,
  output logic [BYTE_W-1:0]                 resp_data,
  output logic                              mem_req,
  output logic [ADDR_W-OFF_W-1:0]           mem_baddr,
  input  logic                              mem_valid,
  input  logic [BYTE_W*(1<<OFF_W)-1:0]      mem_block
);
  localparam int SETS  = 1 << SET_W;
  localparam int TAG_W = ADDR_W - OFF_W - SET_W;
  localparam int BLK_W = BYTE_W * (1 << OFF_W);

  logic [TAG_W-1:0] tag0 [SETS];
  logic [TAG_W-1:0] tag1 [SETS];
  logic [BLK_W-1:0] dat0 [SETS];
  logic [BLK_W-1:0] dat1 [SETS];
  logic [SETS-1:0]  vld0, vld1, lru;
  logic             busy;
  logic [ADDR_W-1:0] pend_addr;

  wire [SET_W-1:0] lk_set = req_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0] lk_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] lk_off = req_addr[OFF_W-1:0];
  wire hit0   = vld0[lk_set] && (tag0[lk_set] == lk_tag);
  wire hit1   = vld1[lk_set] && (tag1[lk_set] == lk_tag);
  wire hit    = hit0 | hit1;
  wire accept = req_valid && !busy;

  wire [SET_W-1:0] f_set = pend_addr[OFF_W +: SET_W];
  wire [TAG_W-1:0] f_tag = pend_addr[ADDR_W-1 -: TAG_W];
  wire [OFF_W-1:0] f_off = pend_addr[OFF_W-1:0];
  wire fill  = busy && mem_valid;
  wire f_way = !vld0[f_set] ? 1'b0 : (!vld1[f_set] ? 1'b1 : lru[f_set]);

  wire [BLK_W-1:0]  hit_blk  = hit1 ? dat1[lk_set] : dat0[lk_set];
  wire [BYTE_W-1:0] hit_byte = hit_blk[int'(lk_off)*BYTE_W +: BYTE_W];
  wire [BYTE_W-1:0] f_byte   = mem_block[int'(f_off)*BYTE_W +: BYTE_W];

  assign req_ready = !busy;
  assign mem_req   = busy;
  assign mem_baddr = pend_addr[ADDR_W-1:OFF_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      pend_addr  <= '0;
      vld0       <= '0;
      vld1       <= '0;
      lru        <= '0;
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (accept) begin
        if (hit) begin
          resp_valid   <= 1'b1;
          resp_hit     <= 1'b1;
          resp_data    <= hit_byte;
          lru[lk_set]  <= hit0;
        end else begin
          busy      <= 1'b1;
          pend_addr <= req_addr;
        end
      end
      if (fill) begin
        busy       <= 1'b0;
        resp_valid <= 1'b1;
        resp_hit   <= 1'b0;
        resp_data  <= f_byte;
        lru[f_set] <= ~f_way;
        if (f_way) vld1[f_set] <= 1'b1;
        else       vld0[f_set] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      if (f_way) begin
        tag1[f_set] <= f_tag;
        dat1[f_set] <= mem_block;
      end else begin
        tag0[f_set] <= f_tag;
        dat0[f_set] <= mem_block;
      end
    end
  end

  p_single_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !(hit0 && hit1));
  p_hit_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit |=> resp_valid && resp_hit && req_ready && !mem_req);
  p_miss_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !hit |=> !req_ready && mem_req && !resp_valid
      && mem_baddr == $past(req_addr[ADDR_W-1:OFF_W]));
  p_fill_answer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fill |=> resp_valid && !resp_hit && req_ready);
  p_way0_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill && !vld0[f_set] |=> vld0[$past(f_set)] && ($past(vld1) == vld1));
  p_lru_hit0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit0 |=> lru[$past(lk_set)]);
  p_lru_hit1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && hit1 |=> !lru[$past(lk_set)]);
endmodule

// File: tb/assoc2_cache_test.sv
module assoc2_cache_test;
  localparam int ADDR_W = 16, OFF_W = 4, SET_W = 2, BYTE_W = 8;
  localparam int BLK_W = BYTE_W * (1 << OFF_W);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, resp_valid, resp_hit, mem_req;
  logic [BYTE_W-1:0] resp_data;
  logic [ADDR_W-OFF_W-1:0] mem_baddr;
  logic mem_valid = 0;
  logic [BLK_W-1:0] mem_block = '0;

  int total = 0, bad = 0, fetches = 0, lat = 3;
  logic [ADDR_W-OFF_W-1:0] last_baddr = '0;
  bit done = 0;

  always #5 clk = ~clk;

  assoc2_cache #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .SET_W(SET_W), .BYTE_W(BYTE_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_data(resp_data), .mem_req(mem_req), .mem_baddr(mem_baddr),
    .mem_valid(mem_valid), .mem_block(mem_block));

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [BLK_W-1:0] mem_blk(input logic [11:0] ba);
    logic [BLK_W-1:0] b;
    for (int i = 0; i < 16; i++) b[i*8 +: 8] = mem_byte({ba, 4'(i)});
    return b;
  endfunction

  function automatic logic [15:0] mk(input int tag, input int set, input int off);
    return {10'(tag), 2'(set), 4'(off)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_valid) mem_valid = 0;
      else if (mem_req) begin
        cnt++;
        if (cnt >= lat) begin
          cnt = 0;
          last_baddr = mem_baddr;
          mem_block = mem_blk(mem_baddr);
          mem_valid = 1;
          fetches++;
        end
      end
    end
  end

  task automatic access(input logic [15:0] a, input bit exp_hit, input string req);
    int f0, n;
    bit stall_ok;
    @(negedge clk);
    f0 = fetches;
    req_valid = 1; req_addr = a;
    chk(req_ready, req, req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    n = 0; stall_ok = 1;
    while (!resp_valid && n < 100) begin
      if (req_ready) stall_ok = 0;
      @(negedge clk);
      n++;
    end
    chk(resp_valid && resp_hit == exp_hit, req, int'(resp_hit), int'(exp_hit));
    chk(resp_data == mem_byte(a), req, resp_data, mem_byte(a));
    chk(fetches - f0 == (exp_hit ? 0 : 1), req, fetches - f0, exp_hit ? 0 : 1);
    if (exp_hit) chk(n == 0, {req, " hit latency"}, n, 0);
    else begin
      chk(stall_ok, {req, " stall"}, int'(stall_ok), 1);
      chk(last_baddr == a[15:4], {req, " block address"}, last_baddr, a[15:4]);
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1 && resp_valid == 0 && mem_req == 0, "R2 reset outputs",
        {req_ready, resp_valid, mem_req}, 3'b100);
    access(16'd6195, 0, "R2 first access misses");
  endtask

  task automatic t_split;
    access(16'd6195, 1, "R1 same byte hits");
    access(16'd6192, 1, "R1 offset 0 of block");
    access(16'd6207, 1, "R1 offset 15 of block");
    access(16'd6195 ^ 16'h0010, 0, "R1 other set misses");
    lat = 6;
    access(mk(5, 3, 2), 0, "R5 second tag fills empty way");
    lat = 1;
    access(16'd6195, 1, "R5 first line kept");
    access(mk(5, 3, 9), 1, "R8 second tag own data");
  endtask

  task automatic t_lru;
    lat = 2;
    access(mk(1, 1, 0), 0, "R6 A");
    access(mk(2, 1, 1), 0, "R6 B");
    access(mk(1, 1, 2), 1, "R6 A again");
    access(mk(3, 1, 3), 0, "R6 C evicts B");
    access(mk(2, 1, 4), 0, "R6 B evicts A");
    access(mk(1, 1, 5), 0, "R6 A evicts C");
    access(mk(2, 1, 6), 1, "R6 B hits");
  endtask

  task automatic t_isolate;
    access(16'd6195, 1, "R7 set 3 way0 survives");
    access(mk(5, 3, 0), 1, "R7 set 3 way1 survives");
    access(16'd6195 ^ 16'h0010, 1, "R7 set 2 survives");
  endtask

  task automatic t_overlap;
    logic [15:0] a = mk(9, 0, 3), b = mk(9, 0, 12);
    int f0, n;
    bit stall_ok = 1;
    lat = 4;
    @(negedge clk);
    f0 = fetches;
    req_valid = 1; req_addr = a;
    @(negedge clk);
    req_addr = b;
    n = 0;
    while (!resp_valid && n < 100) begin
      if (req_ready) stall_ok = 0;
      @(negedge clk);
      n++;
    end
    chk(stall_ok, "R4 waiting request stalled", int'(stall_ok), 1);
    chk(resp_valid && !resp_hit && resp_data == mem_byte(a), "R4 fill answer",
        resp_data, mem_byte(a));
    chk(req_ready, "R4 ready with fill answer", req_ready, 1);
    @(negedge clk);
    req_valid = 0;
    chk(resp_valid && resp_hit, "R3 waiting request hits", int'(resp_hit), 1);
    chk(resp_data == mem_byte(b), "R3 waiting request data", resp_data, mem_byte(b));
    chk(fetches - f0 == 1, "R3 no second fetch", fetches - f0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_split;
    t_lru;
    t_isolate;
    t_overlap;
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule